// File: doc/BRIEF.md
# NAND command queue sequencer

This block drives the pins of raw NAND flash devices from a queue of 32-bit command words. A host pushes words through a small register port. A fetch stage pulls each word out of the queue and decodes it, and an execute stage turns it into pin activity. One word becomes a command-latch byte, an address-latch byte, a single data byte written or read, a timed idle gap, or a wait on a device's ready/busy line. Two chip enables share the data bus and strobes. Each has its own ready/busy input.

The fetch and execute stages can both hold work while the queue itself reads empty. Software that needs to know the controller has gone quiet must therefore look at the busy flag, not only at the queue occupancy. A ready/busy wait holds up every later word until the selected line goes high. When the wait finishes, it can raise a level interrupt that stays set until the host clears it.

Top module: `nand_cmd_seq`

## Requirements
- R1: A word with operation field bits [17:14] equal to 0x5 (command latch), 0x6 (address latch) or 0x4 (data write) drives bits [7:0] onto DQ with the output enable high. For 0x5 it raises CLE and for 0x6 it raises ALE. It holds WE_n low for H clocks and then high for H clocks, and DQ does not change across the WE_n rising edge.
- R2: Bits [13:10] of a word select the chip enable, active low. Code 0xE drives ce_n = 2'b10 (device 0), code 0xD drives ce_n = 2'b01 (device 1), and any other code drives 2'b11. The level is held after the word completes until the next word is executed.
- R3: Operation 0x8 holds RE_n low for H clocks with the DQ output enable low. It captures DQ into the data register (address 3, bits [7:0]) at the RE_n rising edge.
- R4: Operation 0xC is an idle gap. It keeps the execute stage occupied for exactly N clocks, where N is bits [9:0]. N = 0 adds no delay.
- R5: Words are executed in push order. The queue holds 32 words, and its occupancy reads at address 0, bits [27:22].
- R6: Besides the queue, one decoded word may wait in the fetch stage while another executes. The busy flag (address 2, bit 2) stays high while either stage holds work, even when occupancy reads 0.
- R7: A push into a full queue is dropped and sets a sticky overflow flag (address 2, bit 1). Filling the queue to exactly 32 words does not set the flag. Writing 1 to bit 1 of address 2 clears it.
- R8: A word with bit 20 set and operation 0x1 waits for the ready/busy line of its chip-enable code (0xE line 0, 0xD line 1) to read high after a two-flop synchronizer. Later words do not execute until then.
- R9: When configuration bit 21 (address 1) is set, completing a ready/busy wait sets the irq output and status bit 0. They stay set until the host writes 1 to bit 0 of address 2. With bit 21 clear, no interrupt is raised.
- R10: Status bits [27:26] at address 2 show the synchronized ready/busy level of lines 1 and 0.
- R11: H is configuration bits [3:0] at address 1, with a reset value of 2. A value of 0 is treated as 1.
- R12: After reset, ce_n is 2'b11, CLE, ALE, the DQ output enable and irq are low, WE_n and RE_n are high, and occupancy reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr_en | input | 1 | Host write strobe |
| host_addr | input | 2 | Register address for writes and reads (0 queue, 1 config, 2 status, 3 read data) |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Read value of the addressed register |
| nand_ce_n | output | 2 | Chip enables, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_out | output | 8 | Data bus driven value |
| nand_dq_in | input | 8 | Data bus sampled value |
| nand_dq_oe | output | 1 | Data bus output enable |
| nand_rb_n | input | 2 | Ready/busy lines, low while busy |
| irq | output | 1 | Ready/busy completion interrupt, level |

## Verification
The embedded properties check pin safety on every cycle. They cover:
- WE_n and RE_n never low together;
- CLE and ALE never high together;
- DQ never driven while RE_n is low;
- DQ steady at each WE_n rise;
- never both chip enables low;
- the fetch stage never holding two words;
- the queue count staying within depth;
- the overflow and interrupt flags staying sticky and rising only for their cause.

The bench scenarios show what a single-cycle property cannot:
- the byte, strobe widths and chip enable of each word;
- captured read data;
- the exact length of idle gaps (measured as differences);
- execution order;
- the two-stage hold with an empty queue;
- the drop at exactly one word past full;
- ready/busy stalls on the correct line.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

  localparam int WORD_W = 32;
  localparam int ARG_W  = 10;

  localparam logic [1:0] A_QUEUE = 2'd0;
  localparam logic [1:0] A_CFG   = 2'd1;
  localparam logic [1:0] A_STAT  = 2'd2;
  localparam logic [1:0] A_DATA  = 2'd3;

  localparam int CFG_IRQ_EN_BIT = 21;
  localparam int OCC_LSB        = 22;
  localparam int RB_LSB         = 26;

  localparam logic [3:0] OP_CLE  = 4'h5;
  localparam logic [3:0] OP_ALE  = 4'h6;
  localparam logic [3:0] OP_DWR  = 4'h4;
  localparam logic [3:0] OP_DRD  = 4'h8;
  localparam logic [3:0] OP_GAP  = 4'hC;
  localparam logic [3:0] OP_RBW  = 4'h1;
  localparam logic [3:0] SEL_D0  = 4'hE;
  localparam logic [3:0] SEL_D1  = 4'hD;

  typedef enum logic [2:0] {
    K_NOP, K_CLE, K_ALE, K_DWR, K_DRD, K_GAP, K_RBW
  } kind_e;

  typedef struct packed {
    kind_e            kind;
    logic [1:0]       ce_n;
    logic             rb_sel;
    logic [ARG_W-1:0] arg;
  } cmd_t;

  function automatic cmd_t decode_word(input logic [WORD_W-1:0] w);
    cmd_t       c;
    logic [3:0] op;
    logic [3:0] sel;
    op  = w[17:14];
    sel = w[13:10];
    c.arg    = w[ARG_W-1:0];
    c.rb_sel = (sel == SEL_D1);
    case (sel)
      SEL_D0:  c.ce_n = 2'b10;
      SEL_D1:  c.ce_n = 2'b01;
      default: c.ce_n = 2'b11;
    endcase
    if (w[20] && op == OP_RBW) c.kind = K_RBW;
    else begin
      case (op)
        OP_CLE:  c.kind = K_CLE;
        OP_ALE:  c.kind = K_ALE;
        OP_DWR:  c.kind = K_DWR;
        OP_DRD:  c.kind = K_DRD;
        OP_GAP:  c.kind = K_GAP;
        default: c.kind = K_NOP;
      endcase
    end
    return c;
  endfunction

endpackage

// File: rtl/nand_cmd_fifo.sv
module nand_cmd_fifo #(
  parameter int DEPTH = 32,
  parameter int W     = 32,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [W-1:0]  wdata,
  input  logic          pop,
  output logic [W-1:0]  rdata,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          do_push, do_pop;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= wdata;
    if (do_pop)  rdata <= mem[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  a_r5_count_bound: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));
  a_r7_full_no_grow: assert property (@(posedge clk) disable iff (rst)
    (full && push && !pop) |=> (count == CW'(DEPTH)));

endmodule

// File: rtl/nand_cmd_fetch.sv
module nand_cmd_fetch
  import nand_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              q_empty,
  input  logic [WORD_W-1:0] q_rdata,
  input  logic              take,
  output logic              pop,
  output logic              pend,
  output logic              slot_valid,
  output cmd_t              slot
);

  assign pop = !pend && (!slot_valid || take) && !q_empty;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend       <= 1'b0;
      slot_valid <= 1'b0;
      slot       <= '0;
    end else begin
      pend <= pop;
      if (pend) begin
        slot_valid <= 1'b1;
        slot       <= decode_word(q_rdata);
      end else if (take) begin
        slot_valid <= 1'b0;
      end
    end
  end

  a_r6_one_slot: assert property (@(posedge clk) disable iff (rst)
    pend |-> !slot_valid);
  a_r6_take_needs_word: assert property (@(posedge clk) disable iff (rst)
    take |-> slot_valid);

endmodule

// File: rtl/nand_pin_engine.sv
module nand_pin_engine
  import nand_seq_pkg::*;
#(
  parameter int HALF_W = 4,
  localparam int CNT_W = (ARG_W > HALF_W) ? ARG_W : HALF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              slot_valid,
  input  cmd_t              slot,
  input  logic [HALF_W-1:0] half_cfg,
  input  logic [1:0]        rb_lvl,
  input  logic [7:0]        dq_in,
  output logic              take,
  output logic              active,
  output logic              rb_done,
  output logic [1:0]        ce_n,
  output logic              cle,
  output logic              ale,
  output logic              we_n,
  output logic              re_n,
  output logic [7:0]        dq_out,
  output logic              dq_oe,
  output logic [7:0]        rd_byte
);

  typedef enum logic [2:0] {S_IDLE, S_WLO, S_WHI, S_RLO, S_RHI, S_GAP, S_RBW} st_e;

  st_e              st;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] half_eff, half_q;
  logic             rb_sel_q;

  assign half_eff = (half_cfg == '0) ? CNT_W'(1) : CNT_W'(half_cfg);
  assign take     = slot_valid && (st == S_IDLE);
  assign active   = (st != S_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= S_IDLE;
      cnt      <= '0;
      half_q   <= CNT_W'(1);
      rb_sel_q <= 1'b0;
      rb_done  <= 1'b0;
      ce_n     <= 2'b11;
      cle      <= 1'b0;
      ale      <= 1'b0;
      we_n     <= 1'b1;
      re_n     <= 1'b1;
      dq_out   <= '0;
      dq_oe    <= 1'b0;
      rd_byte  <= '0;
    end else begin
      rb_done <= 1'b0;
      case (st)
        S_IDLE: begin
          if (slot_valid) begin
            ce_n   <= slot.ce_n;
            half_q <= half_eff;
            case (slot.kind)
              K_CLE, K_ALE, K_DWR: begin
                cle    <= (slot.kind == K_CLE);
                ale    <= (slot.kind == K_ALE);
                dq_out <= slot.arg[7:0];
                dq_oe  <= 1'b1;
                we_n   <= 1'b0;
                cnt    <= half_eff - 1'b1;
                st     <= S_WLO;
              end
              K_DRD: begin
                re_n <= 1'b0;
                cnt  <= half_eff - 1'b1;
                st   <= S_RLO;
              end
              K_GAP: begin
                if (slot.arg != '0) begin
                  cnt <= CNT_W'(slot.arg);
                  st  <= S_GAP;
                end
              end
              K_RBW: begin
                rb_sel_q <= slot.rb_sel;
                st       <= S_RBW;
              end
              default: ;
            endcase
          end
        end
        S_WLO: begin
          if (cnt == '0) begin
            we_n <= 1'b1;
            cnt  <= half_q - 1'b1;
            st   <= S_WHI;
          end else cnt <= cnt - 1'b1;
        end
        S_WHI: begin
          if (cnt == '0) begin
            cle   <= 1'b0;
            ale   <= 1'b0;
            dq_oe <= 1'b0;
            st    <= S_IDLE;
          end else cnt <= cnt - 1'b1;
        end
        S_RLO: begin
          if (cnt == '0) begin
            re_n    <= 1'b1;
            rd_byte <= dq_in;
            cnt     <= half_q - 1'b1;
            st      <= S_RHI;
          end else cnt <= cnt - 1'b1;
        end
        S_RHI: begin
          if (cnt == '0) st <= S_IDLE;
          else cnt <= cnt - 1'b1;
        end
        S_GAP: begin
          if (cnt == CNT_W'(1)) st <= S_IDLE;
          else cnt <= cnt - 1'b1;
        end
        S_RBW: begin
          if (rb_lvl[rb_sel_q]) begin
            rb_done <= 1'b1;
            st      <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r1_strobes_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(!we_n && !re_n));
  a_r1_latch_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(cle && ale));
  a_r1_dq_held_at_rise: assert property (@(posedge clk) disable iff (rst)
    $rose(we_n) |-> ($stable(dq_out) && dq_oe));
  a_r3_no_drive_in_read: assert property (@(posedge clk) disable iff (rst)
    !re_n |-> !dq_oe);
  a_r2_single_ce: assert property (@(posedge clk) disable iff (rst)
    ce_n != 2'b00);
  a_r8_wait_needs_ready: assert property (@(posedge clk) disable iff (rst)
    $rose(rb_done) |-> $past(rb_lvl[rb_sel_q]));

endmodule

// File: rtl/nand_cmd_seq.sv
module nand_cmd_seq
  import nand_seq_pkg::*;
#(
  parameter int DEPTH    = 32,
  parameter int HALF_W   = 4,
  parameter int HALF_RST = 2,
  localparam int CW      = $clog2(DEPTH + 1)
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        host_wr_en,
  input  logic [1:0]  host_addr,
  input  logic [31:0] host_wdata,
  output logic [31:0] host_rdata,
  output logic [1:0]  nand_ce_n,
  output logic        nand_cle,
  output logic        nand_ale,
  output logic        nand_we_n,
  output logic        nand_re_n,
  output logic [7:0]  nand_dq_out,
  input  logic [7:0]  nand_dq_in,
  output logic        nand_dq_oe,
  input  logic [1:0]  nand_rb_n,
  output logic        irq
);

  logic              q_push, q_pop, q_full, q_empty;
  logic [WORD_W-1:0] q_rdata;
  logic [CW-1:0]     q_count;
  logic              pend, slot_valid, take, eng_active, eng_rb_done;
  cmd_t              slot;
  logic [7:0]        rd_byte;
  logic [1:0]        rb_meta, rb_sync;
  logic              irq_en, irq_q, ovf_q;
  logic [HALF_W-1:0] half_q;
  logic              wr_cfg, wr_stat, clr_irq, clr_ovf, busy;

  assign q_push  = host_wr_en && (host_addr == A_QUEUE);
  assign wr_cfg  = host_wr_en && (host_addr == A_CFG);
  assign wr_stat = host_wr_en && (host_addr == A_STAT);
  assign clr_irq = wr_stat && host_wdata[0];
  assign clr_ovf = wr_stat && host_wdata[1];
  assign busy    = !q_empty || pend || slot_valid || eng_active;

  nand_cmd_fifo #(.DEPTH(DEPTH), .W(WORD_W)) u_fifo (
    .clk(clk), .rst(rst), .push(q_push), .wdata(host_wdata), .pop(q_pop),
    .rdata(q_rdata), .count(q_count), .full(q_full), .empty(q_empty)
  );

  nand_cmd_fetch u_fetch (
    .clk(clk), .rst(rst), .q_empty(q_empty), .q_rdata(q_rdata), .take(take),
    .pop(q_pop), .pend(pend), .slot_valid(slot_valid), .slot(slot)
  );

  nand_pin_engine #(.HALF_W(HALF_W)) u_engine (
    .clk(clk), .rst(rst), .slot_valid(slot_valid), .slot(slot),
    .half_cfg(half_q), .rb_lvl(rb_sync), .dq_in(nand_dq_in),
    .take(take), .active(eng_active), .rb_done(eng_rb_done),
    .ce_n(nand_ce_n), .cle(nand_cle), .ale(nand_ale), .we_n(nand_we_n),
    .re_n(nand_re_n), .dq_out(nand_dq_out), .dq_oe(nand_dq_oe),
    .rd_byte(rd_byte)
  );

  for (genvar i = 0; i < 2; i++) begin : g_rb_sync
    always_ff @(posedge clk) begin
      if (rst) begin
        rb_meta[i] <= 1'b1;
        rb_sync[i] <= 1'b1;
      end else begin
        rb_meta[i] <= nand_rb_n[i];
        rb_sync[i] <= rb_meta[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_en <= 1'b0;
      half_q <= HALF_W'(HALF_RST);
      irq_q  <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      if (wr_cfg) begin
        irq_en <= host_wdata[CFG_IRQ_EN_BIT];
        half_q <= host_wdata[HALF_W-1:0];
      end
      if (eng_rb_done && irq_en) irq_q <= 1'b1;
      else if (clr_irq)          irq_q <= 1'b0;
      if (q_push && q_full)      ovf_q <= 1'b1;
      else if (clr_ovf)          ovf_q <= 1'b0;
    end
  end

  assign irq = irq_q;

  always_comb begin
    host_rdata = '0;
    case (host_addr)
      A_QUEUE: host_rdata[OCC_LSB +: CW] = q_count;
      A_CFG: begin
        host_rdata[CFG_IRQ_EN_BIT] = irq_en;
        host_rdata[HALF_W-1:0]     = half_q;
      end
      A_STAT: begin
        host_rdata[0]           = irq_q;
        host_rdata[1]           = ovf_q;
        host_rdata[2]           = busy;
        host_rdata[RB_LSB +: 2] = rb_sync;
      end
      default: host_rdata[7:0] = rd_byte;
    endcase
  end

  a_r9_irq_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_q) |-> $past(eng_rb_done && irq_en));
  a_r9_irq_sticky: assert property (@(posedge clk) disable iff (rst)
    (irq_q && !clr_irq) |=> irq_q);
  a_r7_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
    (ovf_q && !clr_ovf) |=> ovf_q);
  a_r7_ovf_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(ovf_q) |-> $past(q_push && q_full));

endmodule

// File: tb/nand_cmd_seq_tb.sv
module nand_cmd_seq_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_wr_en = 1'b0;
  logic [1:0]  host_addr = 2'd0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic [1:0]  nand_ce_n;
  logic        nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe, irq;
  logic [7:0]  nand_dq_out;
  logic [7:0]  nand_dq_in = 8'h00;
  logic [1:0]  nand_rb_n = 2'b11;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  nand_cmd_seq u_dut (
    .clk(clk), .rst(rst), .host_wr_en(host_wr_en), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .nand_ce_n(nand_ce_n),
    .nand_cle(nand_cle), .nand_ale(nand_ale), .nand_we_n(nand_we_n),
    .nand_re_n(nand_re_n), .nand_dq_out(nand_dq_out), .nand_dq_in(nand_dq_in),
    .nand_dq_oe(nand_dq_oe), .nand_rb_n(nand_rb_n), .irq(irq)
  );

  // {word[31:0], ce_n[1:0], cle, ale, dq[7:0]}
  localparam logic [43:0] VEC [6] = '{
    {32'h0001_7800, 2'b10, 1'b1, 1'b0, 8'h00},
    {32'h0001_B85A, 2'b10, 1'b0, 1'b1, 8'h5A},
    {32'h0001_34C3, 2'b01, 1'b0, 1'b0, 8'hC3},
    {32'h0001_74FF, 2'b01, 1'b1, 1'b0, 8'hFF},
    {32'h0001_B401, 2'b01, 1'b0, 1'b1, 8'h01},
    {32'h0001_3C77, 2'b11, 1'b0, 1'b0, 8'h77}
  };

  // write-strobe event monitor, sampled at falling clock edges
  int   ev_n = 0;
  int   ev_dq_lo [64];
  int   ev_dq_hi [64];
  int   ev_cle [64];
  int   ev_ale [64];
  int   ev_ce [64];
  int   ev_low [64];
  int   low_cnt = 0;
  int   re_low_total = 0;
  int   oe_in_read = 0;
  logic prev_we = 1'b1;
  int   l_dq, l_cle, l_ale, l_ce;

  always @(negedge clk) begin
    cycles++;
    if (!nand_re_n) begin
      re_low_total++;
      if (nand_dq_oe) oe_in_read++;
    end
    if (!nand_we_n) begin
      low_cnt++;
      l_dq  = nand_dq_out;
      l_cle = nand_cle;
      l_ale = nand_ale;
      l_ce  = nand_ce_n;
    end
    if (nand_we_n && !prev_we && ev_n < 64) begin
      ev_dq_lo[ev_n] = l_dq;
      ev_dq_hi[ev_n] = nand_dq_out;
      ev_cle[ev_n]   = l_cle;
      ev_ale[ev_n]   = l_ale;
      ev_ce[ev_n]    = l_ce;
      ev_low[ev_n]   = low_cnt;
      ev_n++;
      low_cnt = 0;
    end
    prev_we = nand_we_n;
  end

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(negedge clk) begin
    if (cycles == 150000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not end, actual=%0d expected<%0d cycles", cycles, 150000);
      summary();
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    host_addr  = a;
    host_wdata = d;
    host_wr_en = 1'b1;
    @(negedge clk);
    host_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    host_addr = a;
    #1;
    d = host_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int k = 0; k < 3000; k++) begin
      rd(2'd2, s);
      if (!s[2]) break;
    end
  endtask

  task automatic wait_clk(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  // busy span after pushing one idle gap; only differences are compared
  task automatic gap_span(input int n, output int span);
    wr(2'd0, 32'h0003_3800 | n);
    host_addr = 2'd2;
    span = 0;
    for (int k = 0; k < 3000; k++) begin
      #1;
      if (!host_rdata[2]) break;
      span++;
      @(negedge clk);
    end
  endtask

  initial begin
    logic [31:0] r;
    int e0, s0, s5, s10, s40;

    wait_clk(5);
    rst = 1'b0;
    @(negedge clk);

    // R12 reset state
    chk("R12 ce_n", nand_ce_n, 2'b11);
    chk("R12 cle/ale/oe/irq", {nand_cle, nand_ale, nand_dq_oe, irq}, 4'b0000);
    chk("R12 we_n/re_n", {nand_we_n, nand_re_n}, 2'b11);
    rd(2'd0, r);
    chk("R12 occupancy", r[27:22], 0);
    rd(2'd1, r);
    chk("R11 reset half period", r[3:0], 2);

    // R1 R2 vector table
    for (int i = 0; i < 6; i++) begin
      e0 = ev_n;
      wr(2'd0, VEC[i][43:12]);
      wait_idle();
      chk("R1 one strobe per word", ev_n, e0 + 1);
      chk("R2 chip enable during strobe", ev_ce[e0], VEC[i][11:10]);
      chk("R1 cle", ev_cle[e0], VEC[i][9]);
      chk("R1 ale", ev_ale[e0], VEC[i][8]);
      chk("R1 dq byte", ev_dq_lo[e0], VEC[i][7:0]);
      chk("R1 dq stable at we_n rise", ev_dq_hi[e0], VEC[i][7:0]);
      chk("R1 we_n low width", ev_low[e0], 2);
      chk("R2 ce_n held after word", nand_ce_n, VEC[i][11:10]);
    end

    // R11 configurable half period, zero treated as one
    wr(2'd1, 32'h0000_0004);
    e0 = ev_n;
    wr(2'd0, 32'h0001_7811);
    wait_idle();
    chk("R11 width with H=4", ev_low[e0], 4);
    wr(2'd1, 32'h0000_0000);
    e0 = ev_n;
    wr(2'd0, 32'h0001_7812);
    wait_idle();
    chk("R11 width with H=0", ev_low[e0], 1);
    wr(2'd1, 32'h0000_0002);

    // R3 single-byte reads
    nand_dq_in = 8'hA5;
    e0 = re_low_total;
    wr(2'd0, 32'h0002_3400);
    wait_idle();
    rd(2'd3, r);
    chk("R3 captured byte dev1", r[7:0], 8'hA5);
    chk("R3 re_n low width", re_low_total - e0, 2);
    chk("R2 read on dev1 ce_n", nand_ce_n, 2'b01);
    nand_dq_in = 8'h3C;
    wr(2'd0, 32'h0002_3800);
    wait_idle();
    rd(2'd3, r);
    chk("R3 captured byte dev0", r[7:0], 8'h3C);
    chk("R3 dq not driven while re_n low", oe_in_read, 0);

    // R4 idle gap lengths
    gap_span(10, s10);
    wait_idle();
    gap_span(40, s40);
    wait_idle();
    chk("R4 gap 40 vs 10", s40 - s10, 30);
    gap_span(0, s0);
    wait_idle();
    gap_span(5, s5);
    wait_idle();
    chk("R4 gap 5 vs 0", s5 - s0, 5);

    // R5 order
    e0 = ev_n;
    wr(2'd0, 32'h0001_7811);
    wr(2'd0, 32'h0001_B822);
    wr(2'd0, 32'h0001_3833);
    wait_idle();
    chk("R5 order first", ev_dq_lo[e0], 8'h11);
    chk("R5 order second", ev_dq_lo[e0 + 1], 8'h22);
    chk("R5 order third", ev_dq_lo[e0 + 2], 8'h33);

    // R6 R8 R9 R10 ready/busy wait on line 0 with interrupt
    wr(2'd1, 32'h0020_0002);
    nand_rb_n = 2'b10;
    e0 = ev_n;
    wr(2'd0, 32'h0010_7818);
    wr(2'd0, 32'h0001_7890);
    wait_clk(20);
    rd(2'd0, r);
    chk("R6 occupancy zero with work held", r[27:22], 0);
    rd(2'd2, r);
    chk("R6 busy while stages hold work", r[2], 1'b1);
    chk("R10 rb levels while busy", r[27:26], 2'b10);
    chk("R8 later word stalled", ev_n, e0);
    chk("R9 no irq before ready", irq, 1'b0);
    nand_rb_n = 2'b11;
    wait_clk(20);
    chk("R9 irq after wait", irq, 1'b1);
    chk("R8 stalled word ran", ev_n, e0 + 1);
    chk("R8 stalled word byte", ev_dq_lo[e0], 8'h90);
    rd(2'd2, r);
    chk("R9 status irq bit", r[0], 1'b1);
    chk("R10 rb levels ready", r[27:26], 2'b11);
    wait_clk(10);
    chk("R9 irq held", irq, 1'b1);
    wr(2'd2, 32'h0000_0001);
    @(negedge clk);
    chk("R9 irq cleared", irq, 1'b0);

    // R8 line selection: device 1 waits on line 1 only
    nand_rb_n = 2'b01;
    wr(2'd0, 32'h0010_7418);
    wait_clk(20);
    rd(2'd2, r);
    chk("R8 dev1 wait holds on line 1", r[2], 1'b1);
    nand_rb_n = 2'b11;
    wait_idle();
    wr(2'd2, 32'h0000_0001);

    // R9 disabled interrupt, line already ready
    wr(2'd1, 32'h0000_0002);
    wr(2'd0, 32'h0010_7818);
    wait_idle();
    wait_clk(3);
    chk("R9 no irq when disabled", irq, 1'b0);

    // R7 R5 overflow at exactly one past full
    nand_rb_n = 2'b01;
    wr(2'd0, 32'h0010_7418);
    wait_clk(10);
    for (int k = 0; k < 33; k++) wr(2'd0, 32'h0003_3800);
    rd(2'd0, r);
    chk("R5 queue holds 32", r[27:22], 32);
    rd(2'd2, r);
    chk("R7 no overflow at exactly full", r[1], 1'b0);
    wr(2'd0, 32'h0003_3800);
    rd(2'd0, r);
    chk("R7 dropped word not queued", r[27:22], 32);
    rd(2'd2, r);
    chk("R7 overflow set", r[1], 1'b1);
    nand_rb_n = 2'b11;
    wait_idle();
    rd(2'd2, r);
    chk("R7 overflow sticky after drain", r[1], 1'b1);
    wr(2'd2, 32'h0000_0002);
    rd(2'd2, r);
    chk("R7 overflow cleared", r[1], 1'b0);

    summary();
  end

endmodule